// File: doc/BRIEF.md
# Dual-Mode Single-Producer Single-Consumer Pipe

A one-way queue between exactly one producer and one consumer, on one clock. A build-time mode picks what happens when the queue is full. In back-pressure mode the producer is held off: its ready output stays low until a slot is released. In overwrite mode a send is always accepted. A send into a full queue discards the oldest stored entry so that the new one fits.

The consumer sees the head entry and a present flag at all times. It consumes with a single take strobe, and the strobe only takes effect while present is 1. A blocking receive holds take high until present rises. The entry leaves on the first edge where both are high. A test receive pulses take for one cycle. The consumer reads data and present in that cycle, and an empty queue is left untouched. Capacity and data width are parameters, and the one capacity parameter serves both modes. Occupancy, full and empty are exported.

Top module: `spsc_pipe`

## Requirements
- R1: After reset the pipe is empty: fill_count is 0, is_empty is 1, is_full is 0 and rcv_present is 0.
- R2: Entries leave in the order they were accepted, and rcv_data shows the oldest stored entry whenever rcv_present is 1.
- R3: In back-pressure mode (MODE = PIPE_BUFFER), snd_ready is 1 exactly when fill_count is below DEPTH.
- R4: In back-pressure mode, a send offered while the pipe is full is not accepted and leaves contents and count unchanged.
- R5: In overwrite mode (MODE = PIPE_STREAM), snd_ready is always 1.
- R6: In overwrite mode, a send into a full pipe with no take discards the oldest entry, appends the new one and keeps fill_count at DEPTH.
- R7: In overwrite mode, a send and a take in the same cycle on a full pipe deliver the oldest entry to the consumer and drop nothing else.
- R8: A take while the pipe is empty has no effect: rcv_present stays 0 and the count stays 0.
- R9: rcv_present is 1 exactly when the pipe holds an entry. A take while present is 1 removes exactly one entry on that clock edge.
- R10: fill_count never exceeds DEPTH. is_full equals (fill_count == DEPTH) and is_empty equals (fill_count == 0) in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_valid | input | 1 | Producer offers snd_data |
| snd_data | input | WIDTH | Entry offered by the producer |
| snd_ready | output | 1 | Offered entry is accepted on this edge |
| rcv_take | input | 1 | Consumer removes the head entry if present |
| rcv_data | output | WIDTH | Head entry |
| rcv_present | output | 1 | rcv_data holds a valid entry |
| fill_count | output | $clog2(DEPTH+1) | Number of stored entries |
| is_full | output | 1 | fill_count equals DEPTH |
| is_empty | output | 1 | fill_count equals 0 |

## Verification
The assertions assume that the inputs are free of X after reset. They make no assumption about the timing of the handshake, since the producer may hold or drop snd_valid and the consumer may pulse or hold rcv_take in any cycle. The stimulus drives both a back-pressure and an overwrite instance from the same inputs, which change only at the falling edge. It covers several patterns: overfilling, draining, takes on an empty pipe, simultaneous send and take on a full pipe, and a random mix. This way every full-queue and empty-queue corner is reached in each mode.

// File: rtl/pipe_pkg.sv
package pipe_pkg;
    typedef enum logic {
        PIPE_BUFFER = 1'b0,
        PIPE_STREAM = 1'b1
    } pipe_mode_e;
endpackage

// File: rtl/pipe_wrap.sv
module pipe_wrap #(
    parameter int DEPTH = 4,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [AW-1:0] cur,
    output logic [AW-1:0] nxt
);
    localparam bit POW2 = (DEPTH > 1) && ((DEPTH & (DEPTH - 1)) == 0);

    generate
        if (POW2) begin : g_pow2
            assign nxt = cur + AW'(1);
        end else begin : g_cmp
            assign nxt = (cur == AW'(DEPTH - 1)) ? '0 : cur + AW'(1);
        end
    endgenerate
endmodule

// File: rtl/pipe_store.sv
module pipe_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] slot_q [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (we && (waddr == AW'(i))) begin
                    slot_q[i] <= wdata;
                end
            end
        end
    endgenerate

    assign rdata = slot_q[raddr];
endmodule

// File: rtl/spsc_pipe.sv
module spsc_pipe
    import pipe_pkg::*;
#(
    parameter pipe_mode_e MODE  = PIPE_BUFFER,
    parameter int         WIDTH = 8,
    parameter int         DEPTH = 4,
    localparam int        AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int        CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snd_valid,
    input  logic [WIDTH-1:0] snd_data,
    output logic             snd_ready,
    input  logic             rcv_take,
    output logic [WIDTH-1:0] rcv_data,
    output logic             rcv_present,
    output logic [CW-1:0]    fill_count,
    output logic             is_full,
    output logic             is_empty
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
        logic          full;
        logic          empty;
    } pipe_state_t;

    pipe_state_t st_d, st_q;
    logic [AW-1:0] wr_nxt, rd_nxt;
    logic push, pop, adv_rd;

    pipe_wrap #(.DEPTH(DEPTH)) u_wr_wrap (.cur(st_q.wr), .nxt(wr_nxt));
    pipe_wrap #(.DEPTH(DEPTH)) u_rd_wrap (.cur(st_q.rd), .nxt(rd_nxt));

    pipe_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (push),
        .waddr (st_q.wr),
        .wdata (snd_data),
        .raddr (st_q.rd),
        .rdata (rcv_data)
    );

    always_comb begin
        st_d = st_q;
        if (MODE == PIPE_STREAM) begin
            snd_ready = 1'b1;
        end else begin
            snd_ready = !st_q.full;
        end
        push   = snd_valid && snd_ready;
        pop    = rcv_take && !st_q.empty;
        // a full stream pipe drops its head to make room
        adv_rd = pop || (push && st_q.full);
        if (push) begin
            st_d.wr = wr_nxt;
        end
        if (adv_rd) begin
            st_d.rd = rd_nxt;
        end
        case ({push, adv_rd})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
        st_d.full  = (st_d.cnt == CW'(DEPTH));
        st_d.empty = (st_d.cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.wr    <= '0;
            st_q.rd    <= '0;
            st_q.cnt   <= '0;
            st_q.full  <= 1'b0;
            st_q.empty <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rcv_present = !st_q.empty;
    assign fill_count  = st_q.cnt;
    assign is_full     = st_q.full;
    assign is_empty    = st_q.empty;
endmodule

// File: rtl/spsc_pipe_chk.sv
module spsc_pipe_chk
    import pipe_pkg::*;
#(
    parameter pipe_mode_e MODE  = PIPE_BUFFER,
    parameter int         WIDTH = 8,
    parameter int         DEPTH = 4,
    localparam int        CW    = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             snd_valid,
    input logic [WIDTH-1:0] snd_data,
    input logic             snd_ready,
    input logic             rcv_take,
    input logic [WIDTH-1:0] rcv_data,
    input logic             rcv_present,
    input logic [CW-1:0]    fill_count,
    input logic             is_full,
    input logic             is_empty
);
    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CW'(DEPTH));

    // R10
    flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full == (fill_count == CW'(DEPTH))) && (is_empty == (fill_count == '0)));

    // R9
    present_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rcv_present |-> (fill_count != '0));

    // R8
    empty_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_empty && rcv_take && !snd_valid) |=> is_empty);

    // R9
    single_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rcv_present && rcv_take && !snd_valid) |=> (fill_count == $past(fill_count) - CW'(1)));

    generate
        if (MODE == PIPE_BUFFER) begin : g_buf
            // R3
            stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
                is_full |-> !snd_ready);
            // R4
            full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (is_full && !rcv_take) |=> (is_full && $stable(rcv_data)));
        end else begin : g_str
            // R6
            drop_keep_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (is_full && snd_valid && !rcv_take) |=> is_full);
            // R7
            swap_keep_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (is_full && snd_valid && rcv_take) |=> is_full);
        end
    endgenerate
endmodule

bind spsc_pipe spsc_pipe_chk #(.MODE(MODE), .WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .snd_valid   (snd_valid),
    .snd_data    (snd_data),
    .snd_ready   (snd_ready),
    .rcv_take    (rcv_take),
    .rcv_data    (rcv_data),
    .rcv_present (rcv_present),
    .fill_count  (fill_count),
    .is_full     (is_full),
    .is_empty    (is_empty)
);

// File: tb/sim_spsc_pipe.sv
`timescale 1ns/100ps
module sim_spsc_pipe;
    import pipe_pkg::*;
    localparam int WIDTH = 8;
    localparam int DEPTH = 4;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic snd_valid = 1'b0;
    logic [WIDTH-1:0] snd_data = '0;
    logic rcv_take = 1'b0;

    logic b_ready, b_present, b_full, b_empty;
    logic s_ready, s_present, s_full, s_empty;
    logic [WIDTH-1:0] b_data, s_data;
    logic [CW-1:0] b_cnt, s_cnt;

    always #2.5 clk = ~clk;

    spsc_pipe #(.MODE(PIPE_BUFFER), .WIDTH(WIDTH), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .snd_valid(snd_valid), .snd_data(snd_data),
        .snd_ready(b_ready), .rcv_take(rcv_take), .rcv_data(b_data),
        .rcv_present(b_present), .fill_count(b_cnt), .is_full(b_full), .is_empty(b_empty));

    spsc_pipe #(.MODE(PIPE_STREAM), .WIDTH(WIDTH), .DEPTH(DEPTH)) u1 (
        .clk(clk), .rst_n(rst_n), .snd_valid(snd_valid), .snd_data(snd_data),
        .snd_ready(s_ready), .rcv_take(rcv_take), .rcv_data(s_data),
        .rcv_present(s_present), .fill_count(s_cnt), .is_full(s_full), .is_empty(s_empty));

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;
    string cur_tag = "R2";
    logic [WIDTH-1:0] qb[$];
    logic [WIDTH-1:0] qs[$];

    task automatic chk(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R3", "buf ready", int'(b_ready), int'(qb.size() < DEPTH));
        chk("R10", "buf count", int'(b_cnt), qb.size());
        chk("R10", "buf full", int'(b_full), int'(qb.size() == DEPTH));
        chk("R10", "buf empty", int'(b_empty), int'(qb.size() == 0));
        chk(cur_tag, "buf present", int'(b_present), int'(qb.size() > 0));
        if (qb.size() > 0) chk(cur_tag, "buf data", int'(b_data), int'(qb[0]));
        chk("R5", "str ready", int'(s_ready), 1);
        chk("R10", "str count", int'(s_cnt), qs.size());
        chk("R10", "str full", int'(s_full), int'(qs.size() == DEPTH));
        chk("R10", "str empty", int'(s_empty), int'(qs.size() == 0));
        chk(cur_tag, "str present", int'(s_present), int'(qs.size() > 0));
        if (qs.size() > 0) chk(cur_tag, "str data", int'(s_data), int'(qs[0]));
    endtask

    task automatic model_step(input bit v, input logic [WIDTH-1:0] d, input bit t);
        bit pop_b, acc_b, pop_s;
        pop_b = t && (qb.size() > 0);
        acc_b = v && (qb.size() < DEPTH);
        if (pop_b) void'(qb.pop_front());
        if (acc_b) qb.push_back(d);
        pop_s = t && (qs.size() > 0);
        if (v && (qs.size() == DEPTH) && !pop_s) void'(qs.pop_front());
        if (pop_s) void'(qs.pop_front());
        if (v) qs.push_back(d);
    endtask

    task automatic cyc(input bit v, input logic [WIDTH-1:0] d, input bit t);
        @(negedge clk);
        snd_valid = v;
        snd_data  = d;
        rcv_take  = t;
        #1;
        compare_all();
        model_step(v, d, t);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        snd_valid = 1'b0;
        rcv_take = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        qb.delete();
        qs.delete();
        #1;
        cur_tag = "R1";
        compare_all();
        chk("R1", "buf present after reset", int'(b_present), 0);
        chk("R1", "str count after reset", int'(s_cnt), 0);
    endtask

    initial begin
        do_reset();

        // overfill: buffer stalls, stream drops oldest
        cur_tag = "R4";
        for (int i = 0; i < 7; i++) cyc(1'b1, WIDTH'(8'h10 + i), 1'b0);
        cur_tag = "R6";
        cyc(1'b0, '0, 1'b0);

        // drain and watch order
        cur_tag = "R2";
        for (int i = 0; i < 6; i++) cyc(1'b0, '0, 1'b1);

        // takes on an empty pipe
        cur_tag = "R8";
        for (int i = 0; i < 3; i++) cyc(1'b0, '0, 1'b1);
        cyc(1'b0, '0, 1'b0);

        // single test receives
        cur_tag = "R9";
        cyc(1'b1, 8'hA5, 1'b0);
        cyc(1'b0, '0, 1'b1);
        cyc(1'b0, '0, 1'b0);
        cyc(1'b1, 8'h5A, 1'b1);
        cyc(1'b0, '0, 1'b1);

        // full then simultaneous send and take
        cur_tag = "R7";
        for (int i = 0; i < 4; i++) cyc(1'b1, WIDTH'(8'h40 + i), 1'b0);
        for (int i = 0; i < 5; i++) cyc(1'b1, WIDTH'(8'h60 + i), 1'b1);
        for (int i = 0; i < 5; i++) cyc(1'b0, '0, 1'b1);

        // random mix
        cur_tag = "R2";
        for (int i = 0; i < 400; i++)
            cyc(1'($urandom_range(0, 1)), WIDTH'($urandom), 1'($urandom_range(0, 2) == 0));
        for (int i = 0; i < 400; i++)
            cyc(1'($urandom_range(0, 2) == 0), WIDTH'($urandom), 1'($urandom_range(0, 1)));

        // reset while holding data
        for (int i = 0; i < 3; i++) cyc(1'b1, WIDTH'(i), 1'b0);
        do_reset();
        cur_tag = "R2";
        cyc(1'b0, '0, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule